// File: doc/BRIEF.md
# Page Translation Cache with Access Protection

This block holds recently used translations from logical page numbers to physical page frames. Each translation is keyed by the page number and by the privilege level of the access. A lookup is combinational. In the same cycle it returns the physical address, a hit flag, a fault flag, a request for a table search, and two user attribute bits. A page-size input selects 4 KB or 8 KB pages, and the set index moves with it.

The cache has 16 sets of four ways. An external table-walk engine fills it through a load port. Flush commands remove entries, either one translation or all of them. Three conditions turn a tag hit into an access fault: a write or read-modify-write to a write-protected page, a user access to a supervisor-only page, and any access to a page marked non-resident. A write that hits an entry whose modified bit is clear is not granted. The block raises a table-search request instead, so the walker can update the descriptor and reload the entry with the modified bit set.

Top module: `xlat_cache`

## Requirements
- R1: With `pg8k`=0 the set index is `req_addr[15:12]` and the tag is `req_addr[31:16]`. With `pg8k`=1 the set index is `req_addr[16:13]`, the tag is `req_addr[31:17]`, and `req_addr[12]` belongs to the page offset. The load and flush ports take page numbers (`addr[31:12]`) and split them the same way.
- R2: A request hits when some valid way in the indexed set has a matching tag and privilege bit. On a hit that is neither a fault nor a forced re-walk, `hit`=1 and the physical address is formed from the entry's frame and the offset. With 4 KB pages that is `{frame, req_addr[11:0]}`. With 8 KB pages it is `{frame[19:1], req_addr[12:0]}`.
- R3: The privilege bit (`req_super`, 1 = supervisor) is part of the tag. An entry loaded for one privilege level never hits a request at the other level.
- R4: A load takes effect at the next rising edge and sets the entry valid. The way is chosen in this order: the way already holding the same tag and privilege, else the lowest-numbered invalid way, else the set's round-robin pointer. The pointer starts at way 0 after reset and advances by one only when it is used.
- R5: Access kind encoding: 00 = read, 01 = write, 10 = read-modify-write, 11 = read. A hit on a write-protected entry by a write or read-modify-write access gives `fault`=1, `hit`=0 and a physical address of 0. A read of the same entry hits.
- R6: A hit on a supervisor-only entry by a user request (`req_super`=0) gives `fault`=1 and `hit`=0. A supervisor request to that entry hits.
- R7: A hit on an entry whose resident bit is clear gives `fault`=1 for every access kind.
- R8: A request with no tag match gives `walk_req`=1, `hit`=0, `fault`=0 and a physical address of 0.
- R9: A write or read-modify-write that hits a non-faulting entry whose modified bit is clear gives `walk_req`=1, `hit`=0 and `fault`=0. Reads of that entry still hit. Reloading the entry with the modified bit set lets the write hit.
- R10: A selective flush (`fl_one`) invalidates the entries that match its page and privilege. A flush-all (`fl_all`) invalidates every entry. Both act at the next rising edge. Whenever either flush is asserted, a load presented in the same cycle is discarded.
- R11: `upa` carries the two user attribute bits of the hit entry. It is 0 when `hit`=0. With `req_valid`=0, the outputs `hit`, `fault` and `walk_req` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; invalidates all entries |
| pg8k | input | 1 | Page size: 0 = 4 KB, 1 = 8 KB |
| req_valid | input | 1 | Lookup request present |
| req_addr | input | 32 | Logical address of the request |
| req_super | input | 1 | Privilege of the request: 1 = supervisor |
| req_kind | input | 2 | Access kind: 00 read, 01 write, 10 read-modify-write, 11 read |
| hit | output | 1 | Translation granted |
| phys_addr | output | 32 | Physical address; 0 unless hit |
| fault | output | 1 | Access fault on a tag hit |
| walk_req | output | 1 | Table search needed (miss or forced re-walk) |
| upa | output | 2 | User attribute bits of the hit entry |
| ld_valid | input | 1 | Load a translation |
| ld_page | input | 20 | Logical page number to load |
| ld_super | input | 1 | Privilege bit of the loaded entry |
| ld_frame | input | 20 | Physical frame of the loaded entry |
| ld_wp | input | 1 | Write-protect bit |
| ld_so | input | 1 | Supervisor-only bit |
| ld_res | input | 1 | Resident bit |
| ld_mod | input | 1 | Modified bit |
| ld_upa | input | 2 | User attribute bits |
| fl_one | input | 1 | Flush the entries matching `fl_page`/`fl_super` |
| fl_page | input | 20 | Page number for the selective flush |
| fl_super | input | 1 | Privilege bit for the selective flush |
| fl_all | input | 1 | Flush every entry |

## Verification
No register sits between the request and its results. `hit`, `fault`, `walk_req`, `phys_addr` and `upa` are all due in the same cycle as the request. The bench applies each request at a falling edge and samples 1 ns later, well before the next rising edge. A load or flush changes the cache at the first rising edge it is presented to, so the bench holds it for exactly one cycle. Only the requests from the following falling edge onward are expected to see the new contents. The round-robin replacement and the flush-over-load priority are checked the same way, one cycle after the operation.

// File: rtl/xlat_cache.sv
module xlat_cache #(
  parameter int LA_W  = 32,
  parameter int PA_W  = 32,
  parameter int WAYS  = 4,
  parameter int IDX_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pg8k,
  input  logic              req_valid,
  input  logic [LA_W-1:0]   req_addr,
  input  logic              req_super,
  input  logic [1:0]        req_kind,
  output logic              hit,
  output logic [PA_W-1:0]   phys_addr,
  output logic              fault,
  output logic              walk_req,
  output logic [1:0]        upa,
  input  logic              ld_valid,
  input  logic [LA_W-13:0]  ld_page,
  input  logic              ld_super,
  input  logic [PA_W-13:0]  ld_frame,
  input  logic              ld_wp,
  input  logic              ld_so,
  input  logic              ld_res,
  input  logic              ld_mod,
  input  logic [1:0]        ld_upa,
  input  logic              fl_one,
  input  logic [LA_W-13:0]  fl_page,
  input  logic              fl_super,
  input  logic              fl_all
);

  localparam int SETS  = 1 << IDX_W;
  localparam int PG_W  = LA_W - 12;
  localparam int FRM_W = PA_W - 12;
  localparam int TAG_W = PG_W - IDX_W;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  typedef struct packed {
    logic [TAG_W-1:0] tag;
    logic             sup;
    logic [FRM_W-1:0] frm;
    logic             wp;
    logic             so;
    logic             res;
    logic             mod;
    logic [1:0]       ua;
  } ent_t;

  ent_t             ent_q [SETS][WAYS];
  logic [WAYS-1:0]  vld_q [SETS];
  logic [WAY_W-1:0] rr_q  [SETS];

  function automatic logic [IDX_W-1:0] idx_of(input logic [PG_W-1:0] pg, input logic big);
    return big ? pg[1 +: IDX_W] : pg[0 +: IDX_W];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [PG_W-1:0] pg, input logic big);
    return big ? {1'b0, pg[PG_W-1:IDX_W+1]} : pg[PG_W-1:IDX_W];
  endfunction

  // lookup
  wire [PG_W-1:0]  r_pg  = req_addr[LA_W-1:12];
  wire [IDX_W-1:0] r_idx = idx_of(r_pg, pg8k);
  wire [TAG_W-1:0] r_tag = tag_of(r_pg, pg8k);

  logic [WAYS-1:0] r_match;
  ent_t            r_ent;

  always_comb begin
    r_match = '0;
    r_ent   = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (vld_q[r_idx][w] && ent_q[r_idx][w].tag == r_tag && ent_q[r_idx][w].sup == req_super) begin
        r_match[w] = 1'b1;
        r_ent      = ent_q[r_idx][w];
      end
    end
  end

  wire is_wr  = (req_kind == 2'b01) || (req_kind == 2'b10);
  wire any    = req_valid && |r_match;
  wire flt    = any && (!r_ent.res || (r_ent.so && !req_super) || (r_ent.wp && is_wr));
  wire rewalk = any && !flt && is_wr && !r_ent.mod;

  assign hit       = any && !flt && !rewalk;
  assign fault     = flt;
  assign walk_req  = (req_valid && !(|r_match)) || rewalk;
  assign upa       = hit ? r_ent.ua : 2'b00;
  assign phys_addr = !hit ? '0 :
                     pg8k ? {r_ent.frm[FRM_W-1:1], req_addr[12:0]} : {r_ent.frm, req_addr[11:0]};

  // load way choice
  wire [IDX_W-1:0] l_idx = idx_of(ld_page, pg8k);
  wire [TAG_W-1:0] l_tag = tag_of(ld_page, pg8k);

  logic [WAYS-1:0]  l_match;
  logic [WAY_W-1:0] l_way;
  logic             l_use_rr;

  always_comb begin
    l_match = '0;
    for (int w = 0; w < WAYS; w++)
      l_match[w] = vld_q[l_idx][w] && ent_q[l_idx][w].tag == l_tag && ent_q[l_idx][w].sup == ld_super;
    l_way    = rr_q[l_idx];
    l_use_rr = 1'b1;
    if (|l_match) begin
      l_use_rr = 1'b0;
      for (int w = WAYS - 1; w >= 0; w--)
        if (l_match[w]) l_way = WAY_W'(w);
    end else if (~&vld_q[l_idx]) begin
      l_use_rr = 1'b0;
      for (int w = WAYS - 1; w >= 0; w--)
        if (!vld_q[l_idx][w]) l_way = WAY_W'(w);
    end
  end

  // selective flush match
  wire [IDX_W-1:0] f_idx = idx_of(fl_page, pg8k);
  wire [TAG_W-1:0] f_tag = tag_of(fl_page, pg8k);

  logic [WAYS-1:0] f_match;
  always_comb
    for (int w = 0; w < WAYS; w++)
      f_match[w] = ent_q[f_idx][w].tag == f_tag && ent_q[f_idx][w].sup == fl_super;

  wire do_load = ld_valid && !fl_one && !fl_all;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        rr_q[s]  <= '0;
      end
    end else if (fl_all) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else if (fl_one) begin
      vld_q[f_idx] <= vld_q[f_idx] & ~f_match;
    end else if (do_load) begin
      vld_q[l_idx][l_way] <= 1'b1;
      if (l_use_rr) rr_q[l_idx] <= rr_q[l_idx] + 1'b1;
    end
  end

  always_ff @(posedge clk)
    if (do_load)
      ent_q[l_idx][l_way] <= '{tag: l_tag, sup: ld_super, frm: ld_frame, wp: ld_wp,
                               so: ld_so, res: ld_res, mod: ld_mod, ua: ld_upa};

endmodule

module xlat_cache_chk #(
  parameter int LA_W = 32,
  parameter int PA_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [LA_W-1:0] req_addr,
  input logic            hit,
  input logic            fault,
  input logic            walk_req,
  input logic            fl_all,
  input logic [PA_W-1:0] phys_addr,
  input logic [1:0]      upa
);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!hit && !fault && !walk_req));

  // R8
  walk_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req |-> (!hit && !fault));

  // R5
  fault_blocks_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (!hit && phys_addr == '0));

  // R2
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> phys_addr[11:0] == req_addr[11:0]);

  // R10
  flush_all_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fl_all |=> !hit);

  // R11
  upa_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> upa == 2'b00);

endmodule

bind xlat_cache xlat_cache_chk #(.LA_W(LA_W), .PA_W(PA_W)) u_chk (.*);

// File: tb/xlat_cache_bench.sv
module xlat_cache_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pg8k = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_super = 1'b0;
  logic [1:0]  req_kind = 2'b00;
  logic        hit, fault, walk_req;
  logic [31:0] phys_addr;
  logic [1:0]  upa;
  logic        ld_valid = 1'b0;
  logic [19:0] ld_page = '0;
  logic        ld_super = 1'b0;
  logic [19:0] ld_frame = '0;
  logic        ld_wp = 1'b0, ld_so = 1'b0, ld_res = 1'b0, ld_mod = 1'b0;
  logic [1:0]  ld_upa = '0;
  logic        fl_one = 1'b0;
  logic [19:0] fl_page = '0;
  logic        fl_super = 1'b0;
  logic        fl_all = 1'b0;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  xlat_cache u_xlat_cache (.*);

  function automatic logic [19:0] frm_of(input logic [19:0] pg);
    return pg * 20'd13 + 20'd7;
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic load(input logic [19:0] pg, input logic sup, input logic [19:0] frm,
                      input logic wp, input logic so, input logic res, input logic md,
                      input logic [1:0] ua);
    @(negedge clk);
    ld_valid = 1'b1; ld_page = pg; ld_super = sup; ld_frame = frm;
    ld_wp = wp; ld_so = so; ld_res = res; ld_mod = md; ld_upa = ua;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic flush_one(input logic [19:0] pg, input logic sup);
    @(negedge clk);
    fl_one = 1'b1; fl_page = pg; fl_super = sup;
    @(negedge clk);
    fl_one = 1'b0;
  endtask

  task automatic flush_all();
    @(negedge clk);
    fl_all = 1'b1;
    @(negedge clk);
    fl_all = 1'b0;
  endtask

  task automatic look(input logic [31:0] a, input logic sup, input logic [1:0] kind);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_super = sup; req_kind = kind;
    #1;
  endtask

  // expect a granted translation
  task automatic exp_hit(input string rq, input logic [31:0] pa, input logic [1:0] ua);
    chk(hit && !fault && !walk_req && phys_addr == pa && upa == ua, rq,
        {27'd0, hit, fault, walk_req, upa, phys_addr}, {27'd0, 3'b100, ua, pa});
  endtask

  task automatic exp_miss(input string rq);
    chk(!hit && !fault && walk_req && phys_addr == 0 && upa == 0, rq,
        {27'd0, hit, fault, walk_req, upa, phys_addr}, {27'd0, 3'b001, 2'b00, 32'd0});
  endtask

  task automatic exp_fault(input string rq);
    chk(!hit && fault && !walk_req && phys_addr == 0, rq,
        {29'd0, hit, fault, walk_req, phys_addr}, {29'd0, 3'b010, 32'd0});
  endtask

  function automatic logic [19:0] pg4(input int s, input int w);
    return 20'(((w + 1) * 37) << 4) | 20'(s);
  endfunction

  function automatic logic [11:0] off_of(input int s, input int w);
    return 12'((s * 97 + w * 11) & 12'hfff);
  endfunction

  initial begin
    #(20 * 200000);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [19:0] p;
    logic [19:0] n1, n2, n3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R8 R11: reset state
    #1;
    chk(!hit && !fault && !walk_req && upa == 0, "R11 idle after reset", {hit, fault, walk_req}, 3'b000);
    look(32'h1234_5678, 1'b0, 2'b00);
    exp_miss("R8 miss after reset");

    // R1 R2 R4: 4 KB sweep, every set, every way
    for (int s = 0; s < 16; s++)
      for (int w = 0; w < 4; w++)
        load(pg4(s, w), 1'b0, frm_of(pg4(s, w)), 1'b0, 1'b0, 1'b1, 1'b1, 2'(w));
    for (int s = 0; s < 16; s++)
      for (int w = 0; w < 4; w++) begin
        look({pg4(s, w), off_of(s, w)}, 1'b0, 2'b00);
        exp_hit("R2 4K hit", {frm_of(pg4(s, w)), off_of(s, w)}, 2'(w));
      end
    // R3: other privilege misses
    for (int s = 0; s < 16; s += 5) begin
      look({pg4(s, 1), 12'h010}, 1'b1, 2'b00);
      exp_miss("R3 privilege in tag");
    end

    // R4: round robin in set 5 (full, pointer at way 0)
    n1 = 20'h7A005; n2 = 20'h7B005; n3 = 20'h7C005;
    load(n1, 1'b0, 20'h11111, 1'b0, 1'b0, 1'b1, 1'b1, 2'b00);
    look({n1, 12'h0ab}, 1'b0, 2'b00);
    exp_hit("R4 new entry hits", {20'h11111, 12'h0ab}, 2'b00);
    look({pg4(5, 0), 12'h001}, 1'b0, 2'b00);
    exp_miss("R4 oldest evicted");
    look({pg4(5, 1), 12'h002}, 1'b0, 2'b00);
    exp_hit("R4 second kept", {frm_of(pg4(5, 1)), 12'h002}, 2'd1);
    load(n2, 1'b0, 20'h22222, 1'b0, 1'b0, 1'b1, 1'b1, 2'b00);
    look({pg4(5, 1), 12'h002}, 1'b0, 2'b00);
    exp_miss("R4 pointer advanced");
    look({n1, 12'h0ab}, 1'b0, 2'b00);
    exp_hit("R4 previous victim kept", {20'h11111, 12'h0ab}, 2'b00);

    // R10: selective flush, then flush with load in same cycle
    flush_one(pg4(5, 2), 1'b0);
    look({pg4(5, 2), 12'h003}, 1'b0, 2'b00);
    exp_miss("R10 selective flush");
    look({pg4(5, 3), 12'h004}, 1'b0, 2'b00);
    exp_hit("R10 neighbour kept", {frm_of(pg4(5, 3)), 12'h004}, 2'd3);
    @(negedge clk);
    fl_one = 1'b1; fl_page = pg4(5, 3); fl_super = 1'b0;
    ld_valid = 1'b1; ld_page = n3; ld_super = 1'b0; ld_frame = 20'h33333;
    ld_res = 1'b1; ld_mod = 1'b1; ld_wp = 1'b0; ld_so = 1'b0;
    @(negedge clk);
    fl_one = 1'b0; ld_valid = 1'b0;
    look({pg4(5, 3), 12'h004}, 1'b0, 2'b00);
    exp_miss("R10 flush applied");
    look({n3, 12'h004}, 1'b0, 2'b00);
    exp_miss("R10 load dropped under flush");

    // R10: flush all
    flush_all();
    for (int s = 0; s < 16; s++)
      for (int w = 0; w < 4; w++) begin
        look({pg4(s, w), off_of(s, w)}, 1'b0, 2'b00);
        exp_miss("R10 flush all");
      end

    // R5: write protect
    p = 20'h0A001;
    load(p, 1'b0, 20'h0BEEF, 1'b1, 1'b0, 1'b1, 1'b1, 2'b01);
    look({p, 12'h100}, 1'b0, 2'b00);
    exp_hit("R5 read of protected", {20'h0BEEF, 12'h100}, 2'b01);
    look({p, 12'h100}, 1'b0, 2'b01);
    exp_fault("R5 write to protected");
    look({p, 12'h100}, 1'b0, 2'b10);
    exp_fault("R5 rmw to protected");
    look({p, 12'h100}, 1'b0, 2'b11);
    exp_hit("R5 kind 11 reads", {20'h0BEEF, 12'h100}, 2'b01);

    // R6: supervisor only
    p = 20'h0A002;
    load(p, 1'b0, 20'h0C0DE, 1'b0, 1'b1, 1'b1, 1'b1, 2'b00);
    look({p, 12'h200}, 1'b0, 2'b00);
    exp_fault("R6 user to supervisor page");
    p = 20'h0A003;
    load(p, 1'b1, 20'h0C0DF, 1'b0, 1'b1, 1'b1, 1'b1, 2'b11);
    look({p, 12'h200}, 1'b1, 2'b01);
    exp_hit("R6 supervisor access", {20'h0C0DF, 12'h200}, 2'b11);

    // R7: non-resident
    p = 20'h0A004;
    load(p, 1'b0, 20'h0D00D, 1'b0, 1'b0, 1'b0, 1'b1, 2'b00);
    look({p, 12'h300}, 1'b0, 2'b00);
    exp_fault("R7 non-resident read");
    look({p, 12'h300}, 1'b0, 2'b01);
    exp_fault("R7 non-resident write");

    // R9: modified clear forces re-walk, reload replaces same entry
    p = 20'h0A005;
    load(p, 1'b0, 20'h0E001, 1'b0, 1'b0, 1'b1, 1'b0, 2'b10);
    look({p, 12'h400}, 1'b0, 2'b01);
    exp_miss("R9 write with modified clear");
    look({p, 12'h400}, 1'b0, 2'b00);
    exp_hit("R9 read with modified clear", {20'h0E001, 12'h400}, 2'b10);
    load(p, 1'b0, 20'h0E002, 1'b0, 1'b0, 1'b1, 1'b1, 2'b10);
    look({p, 12'h400}, 1'b0, 2'b01);
    exp_hit("R9 write after reload", {20'h0E002, 12'h400}, 2'b10);
    look({p, 12'h404}, 1'b0, 2'b00);
    exp_hit("R4 reload replaced matching way", {20'h0E002, 12'h404}, 2'b10);

    // R11: idle request
    @(negedge clk);
    req_valid = 1'b0; req_addr = {p, 12'h400};
    #1;
    chk(!hit && !fault && !walk_req && upa == 0, "R11 idle with valid entry",
        {hit, fault, walk_req}, 3'b000);

    // R1 R2: 8 KB sweep
    flush_all();
    pg8k = 1'b1;
    for (int s = 0; s < 16; s++)
      for (int w = 0; w < 4; w++)
        load(20'(((w + 3) * 41) << 5) | 20'(s << 1), 1'b0,
             frm_of(20'(((w + 3) * 41) << 5) | 20'(s << 1)), 1'b0, 1'b0, 1'b1, 1'b1, 2'b00);
    for (int s = 0; s < 16; s++)
      for (int w = 0; w < 4; w++) begin
        p = 20'(((w + 3) * 41) << 5) | 20'(s << 1);
        look({p | 20'd1, off_of(s, w)}, 1'b0, 2'b00);
        exp_hit("R1 8K hit", {frm_of(p)[19:1], 1'b1, off_of(s, w)}, 2'b00);
      end
    p = 20'(((0 + 3) * 41) << 5) | 20'(2 << 1);
    look({p ^ 20'h20, 12'h0}, 1'b0, 2'b00);
    exp_miss("R1 8K tag bit 17 differs");

    @(negedge clk);
    req_valid = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule